// File: doc/BRIEF.md
# Manchester II Serial Word Encoder

This block turns 16-bit words into a two-wire Manchester II line signal of the kind used on command/response avionics buses. Every transmitted frame is 20 bit times long. It opens with a three-bit-time sync pattern that marks the word as either a command or a data word. Sixteen Manchester-coded data bits follow, most significant first, and the frame closes with an odd parity bit. The word is not presented in parallel. The encoder raises a request output and captures one serial bit per bit time while that request is high.

The block is clocked by a system clock `clk`. Each half-bit time is one "send tick". By default every `clk` cycle is a send tick, so `clk` runs at twice the bit rate. With `USE_DIV6` set, an internal prescaler produces one send tick every six `clk` cycles, which lets a faster clock drive the encoder. Data flows in as a fixed-rate stream: `data_req` works as a ready signal that cannot be stalled. The source must present the next bit on `bit_in` while `data_req` is high, and there is no back-pressure in either direction. Holding `enable` high sends frames back to back with no gap. An active-high `mreset` pulse aborts the frame in progress.

Top module: `man2_encoder`

## Requirements
- R1: After `rst_n` is released and while no frame is active, `line_pos`, `line_neg` and `data_req` are all 0.
- R2: If the encoder is idle and `enable` is high at a send tick, a frame starts. The frame lasts 40 send ticks, numbered half-bit 0 to 39, and each tick is one half-bit on the line.
- R3: `sync_sel` is sampled at the tick that starts a frame. If it is 1 (command sync), `line_pos` is high for half-bits 0-2 and low for 3-5. If it is 0 (data sync), the pattern is inverted.
- R4: `data_req` is high during half-bits 4 to 35 (16 bit times). The value on `bit_in` is captured at the tick that ends each odd half-bit 5+2j. Bit j of the frame counts from the word's bit 15 down.
- R5: The captured data bit j is sent in half-bits 6+2j and 7+2j. A 1 is sent as high then low on `line_pos`, and a 0 as low then high.
- R6: Half-bits 38 and 39 carry a parity bit, Manchester-coded as in R5. The parity bit makes the total number of ones across the 16 data bits and the parity bit odd.
- R7: If `enable` is high at the tick that ends half-bit 39, the next frame begins at once with half-bit 0 and a freshly sampled `sync_sel`. Otherwise the encoder returns to idle.
- R8: While `inhibit_n` is 0, both line outputs are 1. The sequencing of frames is not affected.
- R9: A send tick with `mreset` high ends any frame and leaves the encoder idle. No frame starts while `mreset` is high.
- R10: During a frame with `inhibit_n` high, `line_neg` is always the complement of `line_pos`.
- R11: With `USE_DIV6` = 1, each half-bit lasts exactly 6 `clk` cycles, so one frame keeps the line active for 240 cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock; every cycle is a send tick unless the prescaler is used |
| rst_n | input | 1 | Synchronous active-low reset of the whole block |
| mreset | input | 1 | Frame abort; takes effect at the next send tick |
| enable | input | 1 | Start / continue frames |
| sync_sel | input | 1 | 1 = command sync, 0 = data sync |
| bit_in | input | 1 | Serial data bit, MSB first |
| inhibit_n | input | 1 | Active-low output inhibit (forces both lines high) |
| data_req | output | 1 | Serial data request window |
| line_pos | output | 1 | Bipolar one output |
| line_neg | output | 1 | Bipolar zero output |

## Verification
A half-bit counter that is off by one shifts the sync edge, the data window or the parity slot. That error shows on `line_pos` or `data_req` within one half-bit of the point where it occurs. A corrupted captured bit or parity register alters the line level two half-bits later, so every half-bit of each frame is compared against a line image computed from the word. A sequencer that fails to stop or restart appears either as activity one tick after a frame should have ended, or as the missing sync of a back-to-back frame.

// File: rtl/man2_enc_pkg.sv
`timescale 1ns/1ps
package man2_enc_pkg;
  localparam int DATA_W      = 16;
  localparam int SYNC_HALVES = 6;
  localparam int HALVES      = SYNC_HALVES + 2 * DATA_W + 2;
  localparam int HB_W        = $clog2(HALVES);
  localparam int REQ_FIRST   = SYNC_HALVES - 2;
  localparam int REQ_LAST    = SYNC_HALVES + 2 * DATA_W - 3;
  localparam int PAR_FIRST   = SYNC_HALVES + 2 * DATA_W;

  typedef enum logic [1:0] {SEG_SYNC, SEG_DATA, SEG_PAR} seg_e;

  typedef struct packed {
    logic            active;
    logic [HB_W-1:0] hb;
    logic            cmd;
    logic            cur_bit;
    logic            par;
  } seq_state_t;
endpackage

// File: rtl/man2_enc_prescaler.sv
`timescale 1ns/1ps
module man2_enc_prescaler #(
  parameter bit USE_DIV = 1'b0,
  parameter int RATIO   = 6
) (
  input  logic clk,
  input  logic rst_n,
  output logic tick
);
  localparam int CW = (RATIO > 1) ? $clog2(RATIO) : 1;

  generate
    if (USE_DIV) begin : g_div
      logic [CW-1:0] cnt;
      always_ff @(posedge clk) begin
        if (!rst_n) cnt <= '0;
        else if (cnt == CW'(RATIO - 1)) cnt <= '0;
        else cnt <= cnt + 1'b1;
      end
      assign tick = (cnt == CW'(RATIO - 1));
    end else begin : g_pass
      assign tick = 1'b1;
    end
  endgenerate
endmodule

// File: rtl/man2_enc_sequencer.sv
`timescale 1ns/1ps
module man2_enc_sequencer
  import man2_enc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tick,
  input  logic       mreset,
  input  logic       enable,
  input  logic       sync_sel,
  input  logic       bit_in,
  output seq_state_t st,
  output logic       data_req
);
  logic in_win, cap, last;

  assign in_win   = st.active && (st.hb >= HB_W'(REQ_FIRST)) && (st.hb <= HB_W'(REQ_LAST));
  assign cap      = in_win && st.hb[0];
  assign last     = st.hb == HB_W'(HALVES - 1);
  assign data_req = in_win;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st <= '0;
    end else if (tick) begin
      if (mreset) begin
        st.active <= 1'b0;
        st.hb     <= '0;
      end else if (!st.active || last) begin
        st.hb <= '0;
        if (enable) begin
          st.active <= 1'b1;
          st.cmd    <= sync_sel;
          st.par    <= 1'b1;
        end else begin
          st.active <= 1'b0;
        end
      end else begin
        st.hb <= st.hb + 1'b1;
        if (cap) begin
          st.cur_bit <= bit_in;
          st.par     <= st.par ^ bit_in;
        end
      end
    end
  end
endmodule

// File: rtl/man2_enc_former.sv
`timescale 1ns/1ps
module man2_enc_former
  import man2_enc_pkg::*;
(
  input  seq_state_t st,
  input  logic       inhibit_n,
  output logic       line_pos,
  output logic       line_neg
);
  seg_e seg;
  logic level;

  always_comb begin
    if (st.hb < HB_W'(SYNC_HALVES))    seg = SEG_SYNC;
    else if (st.hb < HB_W'(PAR_FIRST)) seg = SEG_DATA;
    else                               seg = SEG_PAR;
  end

  always_comb begin
    unique case (seg)
      SEG_SYNC: level = (st.hb < HB_W'(SYNC_HALVES / 2)) ? st.cmd : ~st.cmd;
      SEG_DATA: level = st.cur_bit ^ st.hb[0];
      default:  level = st.par ^ st.hb[0];
    endcase
  end

  always_comb begin
    if (!inhibit_n) begin
      line_pos = 1'b1;
      line_neg = 1'b1;
    end else if (st.active) begin
      line_pos = level;
      line_neg = ~level;
    end else begin
      line_pos = 1'b0;
      line_neg = 1'b0;
    end
  end
endmodule

// File: rtl/man2_encoder.sv
`timescale 1ns/1ps
module man2_encoder
  import man2_enc_pkg::*;
#(
  parameter bit USE_DIV6  = 1'b0,
  parameter int DIV_RATIO = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mreset,
  input  logic enable,
  input  logic sync_sel,
  input  logic bit_in,
  input  logic inhibit_n,
  output logic data_req,
  output logic line_pos,
  output logic line_neg
);
  logic       tick;
  seq_state_t st;
  logic       active;

  assign active = st.active;

  man2_enc_prescaler #(.USE_DIV(USE_DIV6), .RATIO(DIV_RATIO)) u_pre (
    .clk(clk), .rst_n(rst_n), .tick(tick)
  );

  man2_enc_sequencer u_seq (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mreset(mreset), .enable(enable),
    .sync_sel(sync_sel), .bit_in(bit_in), .st(st), .data_req(data_req)
  );

  man2_enc_former u_form (
    .st(st), .inhibit_n(inhibit_n), .line_pos(line_pos), .line_neg(line_neg)
  );
endmodule

// File: rtl/man2_encoder_chk.sv
`timescale 1ns/1ps
module man2_encoder_chk (
  input logic clk,
  input logic rst_n,
  input logic tick,
  input logic mreset,
  input logic active,
  input logic inhibit_n,
  input logic data_req,
  input logic line_pos,
  input logic line_neg
);
  // R10
  compl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (active && inhibit_n) |-> (line_neg == ~line_pos));

  // R1
  idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!active && inhibit_n) |-> (!line_pos && !line_neg && !data_req));

  // R8
  inhibit_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !inhibit_n |-> (line_pos && line_neg));

  // R9
  mreset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tick && mreset) |=> !active);

  // R4
  req_active_chk: assert property (@(posedge clk) disable iff (!rst_n)
    data_req |-> active);
endmodule

bind man2_encoder man2_encoder_chk u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .mreset(mreset), .active(active),
  .inhibit_n(inhibit_n), .data_req(data_req), .line_pos(line_pos), .line_neg(line_neg)
);

// File: tb/man2_encoder_bench.sv
`timescale 1ns/1ps
module man2_encoder_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mreset = 1'b0, enable = 1'b0, sync_sel = 1'b0, bit_in = 1'b0, inhibit_n = 1'b1;
  logic data_req, line_pos, line_neg;
  logic enable2 = 1'b0;
  logic req2, pos2, neg2;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  man2_encoder u_man2_encoder (
    .clk(clk), .rst_n(rst_n), .mreset(mreset), .enable(enable), .sync_sel(sync_sel),
    .bit_in(bit_in), .inhibit_n(inhibit_n), .data_req(data_req),
    .line_pos(line_pos), .line_neg(line_neg)
  );

  man2_encoder #(.USE_DIV6(1'b1)) u_man2_encoder_div6 (
    .clk(clk), .rst_n(rst_n), .mreset(1'b0), .enable(enable2), .sync_sel(1'b1),
    .bit_in(1'b0), .inhibit_n(1'b1), .data_req(req2), .line_pos(pos2), .line_neg(neg2)
  );

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic exp_line(input logic [15:0] w, input logic cmd, input int i);
    logic b;
    if (i < 3) return cmd;
    if (i < 6) return ~cmd;
    if (i < 38) begin
      b = w[15 - (i - 6) / 2];
      return (i % 2 == 0) ? b : ~b;
    end
    b = ~^w;
    return (i % 2 == 0) ? b : ~b;
  endfunction

  // Entry: just after a negedge with enable=1 and sync_sel set; next posedge starts half-bit 0.
  task automatic run_frame(input logic [15:0] w, input logic cmd, input logic nxt_en,
                           input logic nxt_cmd, input int inh_at);
    for (int i = 0; i < 40; i++) begin
      @(posedge clk);
      @(negedge clk);
      if (i == inh_at) begin
        inhibit_n = 1'b0;
        #0.2;
        chk("R8 pos", line_pos, 1);
        chk("R8 neg", line_neg, 1);
        inhibit_n = 1'b1;
        #0.2;
      end
      chk($sformatf("R3/R5/R6 half %0d", i), line_pos, exp_line(w, cmd, i));
      chk("R10", line_neg, !exp_line(w, cmd, i));
      chk($sformatf("R4 req half %0d", i), data_req, (i >= 4 && i <= 35) ? 1 : 0);
      if (i >= 4 && i <= 34 && i % 2 == 0) bit_in = w[15 - (i - 4) / 2];
      if (i == 38) begin
        enable = nxt_en;
        sync_sel = nxt_cmd;
      end
    end
  endtask

  task automatic idle_check(input string tag);
    @(posedge clk);
    @(negedge clk);
    chk({tag, " pos"}, line_pos, 0);
    chk({tag, " neg"}, line_neg, 0);
    chk({tag, " req"}, data_req, 0);
  endtask

  task automatic t_reset();
    repeat (3) @(negedge clk);
    chk("R1 pos", line_pos, 0);
    chk("R1 neg", line_neg, 0);
    chk("R1 req", data_req, 0);
    rst_n = 1'b1;
    idle_check("R1 idle");
  endtask

  task automatic t_single(input logic [15:0] w, input logic cmd);
    enable = 1'b1;
    sync_sel = cmd;
    run_frame(w, cmd, 1'b0, 1'b0, -1);
    idle_check("R7 stop");
  endtask

  task automatic t_back2back();
    enable = 1'b1;
    sync_sel = 1'b1;
    run_frame(16'h8001, 1'b1, 1'b1, 1'b0, -1);
    run_frame(16'h7FFE, 1'b0, 1'b1, 1'b1, -1);
    run_frame(16'h0000, 1'b1, 1'b0, 1'b0, -1);
    idle_check("R7 end");
  endtask

  task automatic t_inhibit();
    enable = 1'b1;
    sync_sel = 1'b0;
    run_frame(16'hC3A5, 1'b0, 1'b0, 1'b0, 17);
    idle_check("R8 after");
  endtask

  task automatic t_mreset();
    enable = 1'b1;
    sync_sel = 1'b1;
    repeat (12) begin
      @(posedge clk);
      @(negedge clk);
    end
    chk("R2 active", line_pos | line_neg, 1);
    mreset = 1'b1;
    enable = 1'b1;
    idle_check("R9 abort");
    idle_check("R9 held");
    mreset = 1'b0;
    t_single(16'h1234, 1'b1);
  endtask

  task automatic t_div6();
    int cnt = 0;
    @(negedge clk);
    enable2 = 1'b1;
    for (int c = 0; c < 400; c++) begin
      @(negedge clk);
      if (c == 10) enable2 = 1'b0;
      if (pos2 | neg2) cnt++;
    end
    chk("R11 frame cycles", cnt, 240);
  endtask

  initial begin
    #(200000 * 5);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_single(16'hA55A, 1'b1);
    t_single(16'h0001, 1'b0);
    t_single(16'hFFFF, 1'b1);
    t_back2back();
    t_inhibit();
    t_mreset();
    t_div6();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule